// File: doc/BRIEF.md
# Expansion-Port Interrupt and Interface Control Registers

This block is the 16-bit register file that sits in front of a combined storage and network expansion port. It gathers interrupt events from the attached peripherals into a sticky cause register. It holds an interrupt enable mask and drives a level interrupt toward the host. It also emits a one-cycle interrupt pulse when a mask update changes which pending events are relevant.

The same register space keeps the DMA, transfer and interface control words and three transfer-timing code registers. It also holds fixed identification words and a capability word built from presence straps. The timing codes are decoded into small mode numbers, with a flag for codes that are not recognised. A set bit in the interface control word forces known timing defaults. A clear bit in that word sends a one-cycle hard-reset pulse to the disk.

Software reaches the block through a word-addressed bus with separate write and read strobes and a two-bit byte enable. Read data appears one clock after the read strobe. All registers clear on a synchronous active-low reset, except the constant identification and capability words.

Top module: `xport_ctrl_regs`

## Requirements
- R1: Every set bit of `cause_in` in a cycle is ORed into the cause register on that clock edge. It is never lost, even when the same edge carries an acknowledge, status or cause-set write.
- R2: `irq` is high exactly when the bitwise AND of the cause register and the mask register is nonzero.
- R3: A full-word write (`bus_be`=2'b11) to address 0x5 stores the mask. `irq_pulse` goes high for the one cycle after that edge only if the new value differs from the old one and (old OR new) AND cause is nonzero. A mask write with any other byte enable is ignored. The mask reads back at 0x5.
- R4: A full-word write to address 0x6 clears every cause bit whose data bit is 1. Address 0x6 reads as zero.
- R5: A write to address 0x3 with `bus_be`=2'b01 loads the cause register with the zero-extended low data byte. Other byte enables at 0x3 are ignored. Any write to address 0x4 sets the cause register to 0x00FF. Address 0x3 reads the cause register.
- R6: Address 0x0 reads 0x0032 and address 0x1 reads 0x0011. Address 0x2 reads the capability word: bit 0 = `net_present`, bit 1 = `disk_present`, bit 5 always 1, all other bits 0.
- R7: A full-word write to interface control (address 0xA) with bit 7 set loads interface control with 0x001A, PIO code with 0x0024, MDMA code with 0x0045 and UDMA code with 0x0083. Without bit 7 the written value is stored.
- R8: A full-word write to address 0xA with bit 6 clear raises `disk_reset_pulse` for the one cycle after that edge. With bit 6 set, no pulse is raised.
- R9: The PIO code (address 0xB) decodes 0x0092, 0x0072, 0x0032, 0x0024 and 0x0023 to `pio_mode` 0 to 4. Any other 16-bit value sets `pio_bad`, and `pio_mode` is then 0.
- R10: The MDMA code (address 0xC) decodes 0x00FF, 0x0045 and 0x0024 to `mdma_mode` 0 to 2. Any other value sets `mdma_bad`, and `mdma_mode` is then 0.
- R11: The UDMA code (address 0xD) decodes 0x00A7, 0x0085, 0x0063, 0x0062 and 0x0061 to `udma_mode` 0 to 4. Any other value sets `udma_bad`, and `udma_mode` is then 0.
- R12: DMA control (0x8) and transfer control (0x9) store full-word writes and read them back. All stored registers reset to zero. `bus_rdata` is loaded one clock after `bus_rd`, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte enable, bit 0 = low byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| cause_in | input | 16 | Interrupt event pulses |
| net_present | input | 1 | Network device strap |
| disk_present | input | 1 | Disk device strap |
| irq | output | 1 | Level interrupt |
| irq_pulse | output | 1 | One-cycle pulse after a qualifying mask write |
| disk_reset_pulse | output | 1 | One-cycle disk hard reset |
| pio_mode | output | 3 | Decoded PIO mode |
| pio_bad | output | 1 | PIO code not recognised |
| mdma_mode | output | 3 | Decoded MDMA mode |
| mdma_bad | output | 1 | MDMA code not recognised |
| udma_mode | output | 3 | Decoded UDMA mode |
| udma_bad | output | 1 | UDMA code not recognised |

## Verification
The mask-pulse rule is driven with four mask writes. One unmasks a pending event. One repeats the same value. One moves the mask away from a pending event, where only the old value overlaps. One moves it between two idle bits. Together these separate the differs-test, the old-value term and the new-value term. Cause updates are tried with an event arriving on the same edge as an acknowledge of that bit, with a byte write versus a word write at the status address, and with the cause-set address. This tells OR-after-write apart from write-wins. Every recognised timing code is walked, along with one unknown code per register and a code whose upper byte is nonzero. The interface reset is checked through the decoded modes it produces, including the UDMA default, which is itself unrecognised.

// File: rtl/xport_regs_pkg.sv
// Package: shared widths, register addresses and interface-control constants
// for the expansion-port register block. Assumes a 16-bit data bus.
package xport_regs_pkg;
    localparam int DW = 16;

    // Word addresses of the register space
    localparam int A_ID0   = 'h0;
    localparam int A_ID1   = 'h1;
    localparam int A_CAPS  = 'h2;
    localparam int A_STAT  = 'h3;
    localparam int A_SET   = 'h4;
    localparam int A_MASK  = 'h5;
    localparam int A_ACK   = 'h6;
    localparam int A_DMA   = 'h8;
    localparam int A_XFR   = 'h9;
    localparam int A_IFC   = 'hA;
    localparam int A_PIO   = 'hB;
    localparam int A_MDMA  = 'hC;
    localparam int A_UDMA  = 'hD;

    // Constant identification words
    localparam logic [DW-1:0] ID0_VAL = 16'h0032;
    localparam logic [DW-1:0] ID1_VAL = 16'h0011;

    // Interface-control bit roles and the defaults its reset bit loads
    localparam int IFC_ATA_RST_BIT  = 7;
    localparam int IFC_DISK_RUN_BIT = 6;
    localparam logic [DW-1:0] IFC_DFLT  = 16'h001A;
    localparam logic [DW-1:0] PIO_DFLT  = 16'h0024;
    localparam logic [DW-1:0] MDMA_DFLT = 16'h0045;
    localparam logic [DW-1:0] UDMA_DFLT = 16'h0083;

    // Decoder variants
    typedef enum int {K_PIO = 0, K_MDMA = 1, K_UDMA = 2} mode_kind_e;
endpackage

// File: rtl/xport_intr_core.sv
// Interrupt core: sticky cause register, mask register, level interrupt and
// a one-cycle pulse on qualifying mask changes. Assumes the write strobes
// arriving here are mutually exclusive (one bus access per cycle).
module xport_intr_core
    import xport_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ev_in,
    input  logic          stat_wr_lo,
    input  logic          set_wr,
    input  logic          mask_wr,
    input  logic          ack_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cause_q,
    output logic [DW-1:0] mask_q,
    output logic          irq,
    output logic          irq_pulse
);
    logic [DW-1:0] cause_nxt;
    logic          pulse_q;

    // Next cause: apply the software write first, then OR in new events
    always_comb begin
        cause_nxt = cause_q;
        if (stat_wr_lo)
            cause_nxt = {{(DW-8){1'b0}}, wdata[7:0]};
        else if (set_wr)
            cause_nxt = {{(DW-8){1'b0}}, 8'hFF};
        else if (ack_wr)
            cause_nxt = cause_q & ~wdata;
        cause_nxt = cause_nxt | ev_in;
    end

    // Cause, mask and mask-change pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            mask_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            cause_q <= cause_nxt;
            if (mask_wr)
                mask_q <= wdata;
            pulse_q <= mask_wr && (wdata != mask_q) && (((mask_q | wdata) & cause_q) != '0);
        end
    end

    assign irq       = (cause_q & mask_q) != '0;
    assign irq_pulse = pulse_q;

    // R1
    ev_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_in != '0) |=> ((cause_q & $past(ev_in)) == $past(ev_in)));
    // R3
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(mask_wr));
    // R3
    pulse_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && wdata != mask_q && ((mask_q | wdata) & cause_q) != '0) |=> irq_pulse);
    // R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q));
endmodule

// File: rtl/xport_ctrl_bank.sv
// Control bank: DMA, transfer and interface control words plus the three
// timing-code registers. Interface reset loads defaults; a clear run bit
// pulses the disk reset. Assumes one write strobe per cycle.
module xport_ctrl_bank
    import xport_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dma_wr,
    input  logic          xfr_wr,
    input  logic          ifc_wr,
    input  logic          pio_wr,
    input  logic          mdma_wr,
    input  logic          udma_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] dma_q,
    output logic [DW-1:0] xfr_q,
    output logic [DW-1:0] ifc_q,
    output logic [DW-1:0] pio_q,
    output logic [DW-1:0] mdma_q,
    output logic [DW-1:0] udma_q,
    output logic          disk_reset_pulse
);
    logic rst_pulse_q;

    // Control and timing registers, with interface-reset defaults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_q  <= '0;
            xfr_q  <= '0;
            ifc_q  <= '0;
            pio_q  <= '0;
            mdma_q <= '0;
            udma_q <= '0;
        end else begin
            if (dma_wr)  dma_q  <= wdata;
            if (xfr_wr)  xfr_q  <= wdata;
            if (pio_wr)  pio_q  <= wdata;
            if (mdma_wr) mdma_q <= wdata;
            if (udma_wr) udma_q <= wdata;
            if (ifc_wr) begin
                if (wdata[IFC_ATA_RST_BIT]) begin
                    ifc_q  <= IFC_DFLT;
                    pio_q  <= PIO_DFLT;
                    mdma_q <= MDMA_DFLT;
                    udma_q <= UDMA_DFLT;
                end else begin
                    ifc_q <= wdata;
                end
            end
        end
    end

    // One-cycle disk hard reset when the run bit is written as zero
    always_ff @(posedge clk) begin
        if (!rst_n) rst_pulse_q <= 1'b0;
        else        rst_pulse_q <= ifc_wr && !wdata[IFC_DISK_RUN_BIT];
    end

    assign disk_reset_pulse = rst_pulse_q;

    // R7
    ata_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ifc_wr && wdata[IFC_ATA_RST_BIT]) |=>
        (ifc_q == IFC_DFLT && pio_q == PIO_DFLT && mdma_q == MDMA_DFLT && udma_q == UDMA_DFLT));
    // R8
    disk_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disk_reset_pulse |-> $past(ifc_wr && !wdata[IFC_DISK_RUN_BIT]));
endmodule

// File: rtl/xport_mode_decode.sv
// Timing-code decoder: maps a 16-bit timing code to a mode number; the KIND
// parameter picks the PIO, MDMA or UDMA code set. Unknown codes raise bad
// and give mode 0. Purely combinational.
module xport_mode_decode
    import xport_regs_pkg::*;
#(
    parameter int KIND = K_PIO
) (
    input  logic [DW-1:0] code,
    output logic [2:0]    mode,
    output logic          bad
);
    generate
        if (KIND == K_PIO) begin : g_pio
            // PIO code table
            always_comb begin
                bad = 1'b0;
                case (code)
                    16'h0092: mode = 3'd0;
                    16'h0072: mode = 3'd1;
                    16'h0032: mode = 3'd2;
                    16'h0024: mode = 3'd3;
                    16'h0023: mode = 3'd4;
                    default: begin mode = 3'd0; bad = 1'b1; end
                endcase
            end
        end else if (KIND == K_MDMA) begin : g_mdma
            // MDMA code table
            always_comb begin
                bad = 1'b0;
                case (code)
                    16'h00FF: mode = 3'd0;
                    16'h0045: mode = 3'd1;
                    16'h0024: mode = 3'd2;
                    default: begin mode = 3'd0; bad = 1'b1; end
                endcase
            end
        end else begin : g_udma
            // UDMA code table
            always_comb begin
                bad = 1'b0;
                case (code)
                    16'h00A7: mode = 3'd0;
                    16'h0085: mode = 3'd1;
                    16'h0063: mode = 3'd2;
                    16'h0062: mode = 3'd3;
                    16'h0061: mode = 3'd4;
                    default: begin mode = 3'd0; bad = 1'b1; end
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/xport_ctrl_regs.sv
// Top: bus decode, read mux and instances of the interrupt core, control
// bank and three timing decoders. Assumes at most one of bus_wr/bus_rd is
// meaningful per cycle and ADDR_W >= 4.
module xport_ctrl_regs
    import xport_regs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic [1:0]        bus_be,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [15:0]       bus_rdata,
    input  logic [15:0]       cause_in,
    input  logic              net_present,
    input  logic              disk_present,
    output logic              irq,
    output logic              irq_pulse,
    output logic              disk_reset_pulse,
    output logic [2:0]        pio_mode,
    output logic              pio_bad,
    output logic [2:0]        mdma_mode,
    output logic              mdma_bad,
    output logic [2:0]        udma_mode,
    output logic              udma_bad
);
    localparam int MAX_PIO  = 4;
    localparam int MAX_MDMA = 2;
    localparam int MAX_UDMA = 4;

    logic          wr_word;
    logic [DW-1:0] cause_q, mask_q, dma_q, xfr_q, ifc_q, pio_q, mdma_q, udma_q;
    logic [DW-1:0] caps, rd_mux, rdata_q;

    // Write qualification: most registers accept whole-word writes only
    assign wr_word = bus_wr && (bus_be == 2'b11);

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
        return a == ADDR_W'(target);
    endfunction

    xport_intr_core u_intr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_in      (cause_in),
        .stat_wr_lo (bus_wr && bus_be == 2'b01 && hit(bus_addr, A_STAT)),
        .set_wr     (bus_wr && hit(bus_addr, A_SET)),
        .mask_wr    (wr_word && hit(bus_addr, A_MASK)),
        .ack_wr     (wr_word && hit(bus_addr, A_ACK)),
        .wdata      (bus_wdata),
        .cause_q    (cause_q),
        .mask_q     (mask_q),
        .irq        (irq),
        .irq_pulse  (irq_pulse)
    );

    xport_ctrl_bank u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .dma_wr           (wr_word && hit(bus_addr, A_DMA)),
        .xfr_wr           (wr_word && hit(bus_addr, A_XFR)),
        .ifc_wr           (wr_word && hit(bus_addr, A_IFC)),
        .pio_wr           (wr_word && hit(bus_addr, A_PIO)),
        .mdma_wr          (wr_word && hit(bus_addr, A_MDMA)),
        .udma_wr          (wr_word && hit(bus_addr, A_UDMA)),
        .wdata            (bus_wdata),
        .dma_q            (dma_q),
        .xfr_q            (xfr_q),
        .ifc_q            (ifc_q),
        .pio_q            (pio_q),
        .mdma_q           (mdma_q),
        .udma_q           (udma_q),
        .disk_reset_pulse (disk_reset_pulse)
    );

    xport_mode_decode #(.KIND(K_PIO))  u_pio  (.code(pio_q),  .mode(pio_mode),  .bad(pio_bad));
    xport_mode_decode #(.KIND(K_MDMA)) u_mdma (.code(mdma_q), .mode(mdma_mode), .bad(mdma_bad));
    xport_mode_decode #(.KIND(K_UDMA)) u_udma (.code(udma_q), .mode(udma_mode), .bad(udma_bad));

    // Capability word from the presence straps
    assign caps = {10'b0, 1'b1, 3'b0, disk_present, net_present};

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        if      (hit(bus_addr, A_ID0))  rd_mux = ID0_VAL;
        else if (hit(bus_addr, A_ID1))  rd_mux = ID1_VAL;
        else if (hit(bus_addr, A_CAPS)) rd_mux = caps;
        else if (hit(bus_addr, A_STAT)) rd_mux = cause_q;
        else if (hit(bus_addr, A_MASK)) rd_mux = mask_q;
        else if (hit(bus_addr, A_DMA))  rd_mux = dma_q;
        else if (hit(bus_addr, A_XFR))  rd_mux = xfr_q;
        else if (hit(bus_addr, A_IFC))  rd_mux = ifc_q;
        else if (hit(bus_addr, A_PIO))  rd_mux = pio_q;
        else if (hit(bus_addr, A_MDMA)) rd_mux = mdma_q;
        else if (hit(bus_addr, A_UDMA)) rd_mux = udma_q;
    end

    // Registered read data, one clock after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    // R9
    pio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pio_bad ? (pio_mode == 3'd0) : (int'(pio_mode) <= MAX_PIO));
    // R10
    mdma_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdma_bad ? (mdma_mode == 3'd0) : (int'(mdma_mode) <= MAX_MDMA));
    // R11
    udma_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        udma_bad ? (udma_mode == 3'd0) : (int'(udma_mode) <= MAX_UDMA));
    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/xport_ctrl_regs_test.sv
module xport_ctrl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_be = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic [15:0] cause_in = '0;
    logic        net_present = 1'b1;
    logic        disk_present = 1'b0;
    logic        irq, irq_pulse, disk_reset_pulse;
    logic [2:0]  pio_mode, mdma_mode, udma_mode;
    logic        pio_bad, mdma_bad, udma_bad;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    xport_ctrl_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cause_in(cause_in), .net_present(net_present), .disk_present(disk_present),
        .irq(irq), .irq_pulse(irq_pulse), .disk_reset_pulse(disk_reset_pulse),
        .pio_mode(pio_mode), .pio_bad(pio_bad), .mdma_mode(mdma_mode),
        .mdma_bad(mdma_bad), .udma_mode(udma_mode), .udma_bad(udma_bad)
    );

    // Vector: {kind[1:0], code[7:0], bad, mode[2:0]}; kind 0=PIO 1=MDMA 2=UDMA
    localparam logic [13:0] VEC [0:15] = '{
        {2'd0, 8'h92, 1'b0, 3'd0}, {2'd0, 8'h72, 1'b0, 3'd1}, {2'd0, 8'h32, 1'b0, 3'd2},
        {2'd0, 8'h24, 1'b0, 3'd3}, {2'd0, 8'h23, 1'b0, 3'd4}, {2'd0, 8'h33, 1'b1, 3'd0},
        {2'd1, 8'hFF, 1'b0, 3'd0}, {2'd1, 8'h45, 1'b0, 3'd1}, {2'd1, 8'h24, 1'b0, 3'd2},
        {2'd1, 8'h23, 1'b1, 3'd0},
        {2'd2, 8'hA7, 1'b0, 3'd0}, {2'd2, 8'h85, 1'b0, 3'd1}, {2'd2, 8'h63, 1'b0, 3'd2},
        {2'd2, 8'h62, 1'b0, 3'd3}, {2'd2, 8'h61, 1'b0, 3'd4}, {2'd2, 8'h83, 1'b1, 3'd0}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 2'b00;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ev(input logic [15:0] v);
        @(negedge clk);
        cause_in = v;
        @(negedge clk);
        cause_in = '0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(4'h3, r); check("R12 reset cause", r, 16'h0000);
        check("R2 reset irq", {15'b0, irq}, 16'h0);
        check("R3 reset pulse", {15'b0, irq_pulse}, 16'h0);
        rd(4'h0, r); check("R6 id0", r, 16'h0032);
        rd(4'h1, r); check("R6 id1", r, 16'h0011);
        rd(4'h2, r); check("R6 caps net", r, 16'h0021);
        rd(4'hA, r); check("R12 reset ifc", r, 16'h0000);
        check("R9 reset code bad", {15'b0, pio_bad}, 16'h1);

        // Table walk over timing codes (R9 R10 R11)
        for (int i = 0; i < 16; i++) begin
            logic [1:0] k;
            k = VEC[i][13:12];
            wr(4'hB + {2'b0, k}, {8'h00, VEC[i][11:4]}, 2'b11);
            case (k)
                2'd0: check("R9 pio decode", {12'b0, pio_bad, pio_mode}, {12'b0, VEC[i][3:0]});
                2'd1: check("R10 mdma decode", {12'b0, mdma_bad, mdma_mode}, {12'b0, VEC[i][3:0]});
                default: check("R11 udma decode", {12'b0, udma_bad, udma_mode}, {12'b0, VEC[i][3:0]});
            endcase
        end
        wr(4'hB, 16'h0124, 2'b11);
        check("R9 upper byte code", {12'b0, pio_bad, pio_mode}, 16'h0008);

        // Event accumulation
        ev(16'h0001); ev(16'h0004);
        rd(4'h3, r); check("R1 events ORed", r, 16'h0005);
        check("R2 masked off", {15'b0, irq}, 16'h0);

        // Mask-change pulse rule
        wr(4'h5, 16'h0004, 2'b11);
        check("R3 unmask pulse", {15'b0, irq_pulse}, 16'h1);
        check("R2 irq on", {15'b0, irq}, 16'h1);
        @(negedge clk);
        check("R3 pulse one cycle", {15'b0, irq_pulse}, 16'h0);
        wr(4'h5, 16'h0004, 2'b11);
        check("R3 same mask no pulse", {15'b0, irq_pulse}, 16'h0);
        wr(4'h5, 16'h0008, 2'b11);
        check("R3 old mask overlap pulse", {15'b0, irq_pulse}, 16'h1);
        check("R2 irq off", {15'b0, irq}, 16'h0);
        wr(4'h5, 16'h0010, 2'b11);
        check("R3 idle change no pulse", {15'b0, irq_pulse}, 16'h0);
        wr(4'h5, 16'h0004, 2'b01);
        rd(4'h5, r); check("R3 partial mask ignored", r, 16'h0010);

        // Acknowledge
        wr(4'h6, 16'h0001, 2'b11);
        rd(4'h3, r); check("R4 ack clears", r, 16'h0004);
        rd(4'h6, r); check("R4 ack reads zero", r, 16'h0000);

        // Event on the same edge as an acknowledge of that bit
        @(negedge clk);
        bus_addr = 4'h6; bus_wdata = 16'h0006; bus_be = 2'b11; bus_wr = 1'b1;
        cause_in = 16'h0004;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 2'b00; cause_in = '0;
        rd(4'h3, r); check("R1 event beats ack", r, 16'h0004);

        // Direct cause writes
        wr(4'h3, 16'h12A5, 2'b01);
        rd(4'h3, r); check("R5 low byte overwrite", r, 16'h00A5);
        wr(4'h3, 16'h0000, 2'b11);
        rd(4'h3, r); check("R5 word write ignored", r, 16'h00A5);
        wr(4'h4, 16'h0000, 2'b11);
        rd(4'h3, r); check("R5 cause set", r, 16'h00FF);
        wr(4'h5, 16'h0001, 2'b11);
        check("R3 pulse after set", {15'b0, irq_pulse}, 16'h1);
        wr(4'h6, 16'h00FF, 2'b11);
        check("R2 irq cleared by ack", {15'b0, irq}, 16'h0);

        // Capability straps
        net_present = 1'b0; disk_present = 1'b1;
        rd(4'h2, r); check("R6 caps disk", r, 16'h0022);

        // Control words and unmapped read
        wr(4'h8, 16'h1234, 2'b11);
        rd(4'h8, r); check("R12 dma readback", r, 16'h1234);
        wr(4'h9, 16'h0081, 2'b11);
        rd(4'h9, r); check("R12 xfr readback", r, 16'h0081);
        rd(4'h7, r); check("R12 unmapped zero", r, 16'h0000);

        // Interface reset and disk reset
        wr(4'hA, 16'h0080, 2'b11);
        check("R8 disk pulse", {15'b0, disk_reset_pulse}, 16'h1);
        check("R7 pio default", {12'b0, pio_bad, pio_mode}, 16'h0003);
        check("R7 mdma default", {12'b0, mdma_bad, mdma_mode}, 16'h0001);
        check("R7 udma default bad", {12'b0, udma_bad, udma_mode}, 16'h0008);
        @(negedge clk);
        check("R8 pulse one cycle", {15'b0, disk_reset_pulse}, 16'h0);
        rd(4'hA, r); check("R7 ifc default", r, 16'h001A);
        rd(4'hD, r); check("R7 udma code", r, 16'h0083);
        wr(4'hA, 16'h0040, 2'b11);
        check("R8 run bit no pulse", {15'b0, disk_reset_pulse}, 16'h0);
        rd(4'hA, r); check("R7 plain ifc write", r, 16'h0040);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule